// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Line Timeout Watchdog

This block sits beside the slave protocol engine of a two-wire serial interface. It watches the already synchronized clock and data lines and the engine's busy flag. When either line stays low for too long during a transfer, it raises a one-cycle request that makes the serial interface reset itself. After that reset the interface lets go of the data line, returns it to input, and ignores the bus until the next start condition.

The watchdog arms only when it sees a start condition on the lines. Its window is 45 ms, set by a parameter in microseconds that must fall within 30 to 60 ms, and counted in system clocks from a clock-frequency parameter. The register file supplies an enable bit, which it resets to 1. Clearing that bit stops and clears the watchdog at run time.

Top module: `twi_stuck_watchdog`

## Requirements
- R1: After reset `tmo_rst_o` is 0 and the watchdog is disarmed. Lines held low without a start condition never produce a request.
- R2: A start condition is SDA going 1 to 0 while SCL is 1 on both the previous and the current cycle. It arms the watchdog and clears the low-time count.
- R3: A cycle counts when the watchdog is armed, enabled, `busy_i` is 1 and at least one line is 0. `tmo_rst_o` is 1 in the cycle after the LIMIT-th counted cycle, where LIMIT = CLK_HZ*TIMEOUT_US/1000000.
- R4: The count saturates at LIMIT, so one stuck episode gives exactly one pulse, one cycle wide.
- R5: A cycle with both lines at 1 clears the count but leaves the watchdog armed.
- R6: A stop condition is SDA going 0 to 1 while SCL is 1 on both cycles. It disarms the watchdog and clears the count.
- R7: With `en_i` at 0 the count is held at zero and no pulse is issued. This holds in the cycle where the pulse would have come. The armed state is kept.
- R8: With `busy_i` at 0 the count pauses at its value without clearing.
- R9: A pulse disarms the watchdog. No further pulse comes until a new start condition re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| busy_i | input | 1 | Slave engine reports a transfer in progress |
| en_i | input | 1 | Watchdog enable from the register file |
| tmo_rst_o | output | 1 | One-cycle reset request to the serial interface |

## Verification
A run-time disable of the watchdog can land in the very cycle in which the count would complete. The bench drives a start, holds the lines low for LIMIT-1 counted cycles, and then drops `en_i` for the final counting edge. It expects no pulse there or later. After re-enabling, it expects a pulse exactly LIMIT counted cycles later, which shows the count was cleared and not just paused. A second overlap is also provoked: a both-lines-high clear against the last counted cycle. The bench sweeps the low time across LIMIT-2 to LIMIT and checks arithmetically whether a pulse occurs in each phase.

// File: rtl/twi_wd_pkg.sv
package twi_wd_pkg;

   typedef enum logic [1:0] {
      BUS_EV_NONE  = 2'd0,
      BUS_EV_START = 2'd1,
      BUS_EV_STOP  = 2'd2
   } bus_ev_e;

   // Number of system clocks in a window of win_us microseconds.
   function automatic longint calc_limit(input longint clk_hz, input longint win_us);
      return (clk_hz * win_us) / 64'd1000000;
   endfunction

endpackage

// File: rtl/twi_wd_cond.sv
module twi_wd_cond (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output twi_wd_pkg::bus_ev_e  ev_o
);
   import twi_wd_pkg::*;

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      ev_o = BUS_EV_NONE;
      if (scl_q && scl_i) begin
         if (sda_q && !sda_i)      ev_o = BUS_EV_START;
         else if (!sda_q && sda_i) ev_o = BUS_EV_STOP;
      end
   end
endmodule

// File: rtl/twi_wd_arm.sv
module twi_wd_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic fire_i,
   output logic armed_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                armed_o <= 1'b0;
      else if (start_i)          armed_o <= 1'b1;
      else if (stop_i || fire_i) armed_o <= 1'b0;
   end
endmodule

// File: rtl/twi_wd_lowcnt.sv
module twi_wd_lowcnt #(
   parameter int LIMIT    = 4500,
   parameter int CW       = $clog2(LIMIT + 1),
   parameter bit FIRE_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   output logic [CW-1:0] cnt_o,
   output logic          fire_o
);
   localparam logic [CW-1:0] CAP     = CW'(LIMIT);
   localparam logic [CW-1:0] PRE_CAP = CW'(LIMIT - 1);

   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_o <= '0;
      else if (clr_i)                    cnt_o <= '0;
      else if (step_i && cnt_o != CAP)   cnt_o <= cnt_o + 1'b1;
   end

   assign hit = !clr_i && step_i && (cnt_o == PRE_CAP);

   generate
      if (FIRE_REG) begin : g_fire_reg
         logic fire_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= hit;
         end
         assign fire_o = fire_q;
      end else begin : g_fire_comb
         assign fire_o = hit;
      end
   endgenerate
endmodule

// File: rtl/twi_stuck_watchdog.sv
module twi_stuck_watchdog #(
   parameter longint CLK_HZ     = 100_000_000,
   parameter int     TIMEOUT_US = 45_000,
   parameter bit     FIRE_REG   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic busy_i,
   input  logic en_i,
   output logic tmo_rst_o
);
   import twi_wd_pkg::*;

   localparam longint LIMIT_L = calc_limit(CLK_HZ, longint'(TIMEOUT_US));
   localparam int     LIMIT   = int'(LIMIT_L);
   localparam int     CW      = $clog2(LIMIT + 1);

   generate
      if (TIMEOUT_US < 30_000 || TIMEOUT_US > 60_000) begin : g_bad_window
         $error("TIMEOUT_US must lie within 30000..60000");
      end
      if (LIMIT_L < 2 || LIMIT_L > 64'd2000000000) begin : g_bad_limit
         $error("clock frequency gives an unusable count limit");
      end
   endgenerate

   bus_ev_e       ev;
   logic          is_start;
   logic          is_stop;
   logic          armed;
   logic          clr;
   logic          step;
   logic [CW-1:0] cnt;

   twi_wd_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev_o  (ev)
   );

   assign is_start = (ev == BUS_EV_START);
   assign is_stop  = (ev == BUS_EV_STOP);

   twi_wd_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (is_start),
      .stop_i  (is_stop),
      .fire_i  (tmo_rst_o),
      .armed_o (armed)
   );

   assign clr  = !en_i || is_start || is_stop || (scl_i && sda_i);
   assign step = armed && busy_i && (!scl_i || !sda_i);

   twi_wd_lowcnt #(
      .LIMIT    (LIMIT),
      .CW       (CW),
      .FIRE_REG (FIRE_REG)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .step_i (step),
      .cnt_o  (cnt),
      .fire_o (tmo_rst_o)
   );
endmodule

// File: rtl/twi_wd_check.sv
module twi_wd_check #(
   parameter int LIMIT    = 4500,
   parameter int CW       = 13,
   parameter bit FIRE_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_i,
   input logic          en_i,
   input logic          tmo_rst_o,
   input logic          armed,
   input logic          is_start,
   input logic          is_stop,
   input logic [CW-1:0] cnt
);
   AST_ONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) tmo_rst_o |=> !tmo_rst_o); // R4
   AST_CNT_CAP:     assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(LIMIT)); // R4
   AST_START_ARMS:  assert property (@(posedge clk) disable iff (!rst_n) is_start |=> armed); // R2
   AST_STOP_DISARM: assert property (@(posedge clk) disable iff (!rst_n) is_stop |=> !armed); // R6
   AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (scl_i && sda_i) |=> (cnt == '0)); // R5
   AST_FIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n) (tmo_rst_o && !is_start) |=> !armed); // R9

   generate
      if (FIRE_REG) begin : g_reg_checks
         AST_FIRE_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n) tmo_rst_o |-> (cnt == CW'(LIMIT))); // R3
         AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !en_i |=> !tmo_rst_o); // R7
      end else begin : g_comb_checks
         AST_FIRE_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n) tmo_rst_o |-> (cnt == CW'(LIMIT - 1))); // R3
         AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !en_i |-> !tmo_rst_o); // R7
      end
   endgenerate
endmodule

bind twi_stuck_watchdog twi_wd_check #(
   .LIMIT    (LIMIT),
   .CW       (CW),
   .FIRE_REG (FIRE_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_i     (sda_i),
   .en_i      (en_i),
   .tmo_rst_o (tmo_rst_o),
   .armed     (armed),
   .is_start  (is_start),
   .is_stop   (is_stop),
   .cnt       (cnt)
);

// File: tb/twi_stuck_watchdog_bench.sv
module twi_stuck_watchdog_bench;
   localparam longint HZ  = 100_000;
   localparam int     WUS = 45_000;
   localparam int     LIM = 100 * 45;   // 100 kHz * 45 ms

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, busy = 1'b1, en = 1'b1;
   logic tmo;

   int compared = 0;
   int mismatched = 0;
   int pulses = 0;

   always #5 clk = ~clk;

   twi_stuck_watchdog #(.CLK_HZ(HZ), .TIMEOUT_US(WUS)) u_twi_stuck_watchdog (
      .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda),
      .busy_i (busy), .en_i (en), .tmo_rst_o (tmo)
   );

   always @(negedge clk) if (rst_n && tmo) pulses <= pulses + 1;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: got %0d, expected %0d", req, act, exp);
      end
   endtask

   // Idle both high, then SDA falls with SCL high; returns just after the start edge.
   task automatic do_start();
      scl = 1'b1; sda = 1'b1; step(2);
      sda = 1'b0; step(1);
   endtask

   task automatic do_stop();
      scl = 1'b1; step(1);
      sda = 1'b1; step(2);
   endtask

   // Expect the pulse exactly after n more counted edges.
   task automatic expect_fire(input string req, input int n);
      int p0;
      p0 = pulses;
      step(n - 1);
      chk(req, int'(tmo), 0);
      step(1);
      chk(req, int'(tmo), 1);
      step(1);
      chk(req, int'(tmo), 0);
      chk(req, pulses - p0, 1);
   endtask

   task automatic run_all();
      int p0;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 reset output", int'(tmo), 0);

      // R1: low lines without a start condition
      scl = 1'b0; step(1); sda = 1'b0; p0 = pulses; step(LIM + 1500);
      chk("R1 no start no pulse", pulses - p0, 0);

      // R2 R3: exact pulse position; R4: single pulse on a long hold
      do_start();
      expect_fire("R3 fire position", LIM);
      p0 = pulses; step(8000);
      chk("R4 single pulse", pulses - p0, 0);

      // R9: a fresh start re-arms
      do_start();
      expect_fire("R9 re-arm after start", LIM);
      do_stop();

      // R5 R9 sweep: L counted low edges, both-high clear, then a second episode
      for (int L = LIM - 2; L <= LIM; L++) begin
         do_start();
         p0 = pulses;
         scl = 1'b0; step(L - 1);
         sda = 1'b1; step(1);
         scl = 1'b1; step(1);
         chk("R5 first phase pulses", pulses - p0, (L >= LIM) ? 1 : 0);
         p0 = pulses;
         scl = 1'b0; step(LIM + 2);
         chk("R5 second phase pulses", pulses - p0, (L >= LIM) ? 0 : 1);
         do_stop();
      end

      // R6: stop disarms
      do_start();
      step(10);
      sda = 1'b1; step(1);
      scl = 1'b0; step(1); sda = 1'b0; p0 = pulses; step(LIM + 1500);
      chk("R6 stop disarms", pulses - p0, 0);

      // R7: disabled holds zero, armed state kept
      en = 1'b0;
      do_start();
      p0 = pulses; step(LIM + 1500);
      chk("R7 disabled quiet", pulses - p0, 0);
      en = 1'b1;
      expect_fire("R7 re-enable counts from zero", LIM);
      do_stop();

      // R7: disable in the cycle the pulse would issue
      do_start();
      step(LIM - 1);
      en = 1'b0; p0 = pulses; step(1);
      chk("R7 disable at last edge", int'(tmo), 0);
      step(1);
      chk("R7 disable at last edge", pulses - p0, 0);
      en = 1'b1;
      expect_fire("R7 cleared not paused", LIM);
      do_stop();

      // R8: busy low pauses without clearing
      do_start();
      step(100);
      busy = 1'b0; p0 = pulses; step(LIM + 500);
      chk("R8 paused", pulses - p0, 0);
      busy = 1'b1;
      expect_fire("R8 resumes count", LIM - 100);
      do_stop();
   endtask

   initial begin
      run_all();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (190_000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule